// File: doc/BRIEF.md
# Non-revertive Reference Clock Selector

This controller decides which of two reference clocks drives the phase detector of a clock PLL. It produces the select line for the external clock mux and an acknowledge bit that reports the input in use. Both come from the same register, so the acknowledge always matches the routed input. When automatic mode is off, the choice follows a select pin. When automatic mode is on, the controller takes the pin's value once, on entry, and then holds it. If the PLL's loss-of-lock flag stays high long enough, it moves to the other input.

An automatic move happens at most once per enabling of automatic mode, and the controller never returns to the original input by itself. To allow another move, automatic mode must be dropped and raised again. Each automatic move produces a one-cycle event pulse. The three control inputs are asynchronous to the controller clock. Each passes through a synchronizer of `SYNC_STAGES` flops. The loss-of-lock flag must then stay high for `FAULT_CYCLES` consecutive synchronized cycles before it counts as a fault.

Top module: `refclk_autoselect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mux_sel` and `ref_ack` are 0 (reference 0) and `switch_evt` is 0.
- R2: With `auto_mode` low, `mux_sel` follows `ref_pick` (1 selects reference 1, 0 selects reference 0). A change at the pin appears SYNC_STAGES+1 clock edges later.
- R3: `ref_ack` equals `mux_sel` in every cycle (1 means input pair 1, 0 means input pair 0).
- R4: When synchronized `auto_mode` rises, the selection takes the synchronized `ref_pick` value at that edge.
- R5: While `auto_mode` stays high, changes on `ref_pick` have no effect on `mux_sel`.
- R6: A run of `lock_lost` high shorter than FAULT_CYCLES synchronized cycles causes no switch.
- R7: In automatic mode, before any switch, FAULT_CYCLES consecutive synchronized high cycles of `lock_lost` invert `mux_sel`. This happens SYNC_STAGES+FAULT_CYCLES edges after `lock_lost` rises at the pin, and `switch_evt` is high for exactly that one cycle.
- R8: After an automatic switch, no further switch occurs while `auto_mode` stays high, whatever `lock_lost` does.
- R9: Taking `auto_mode` low and then high again re-arms the controller, so one more automatic switch can happen.
- R10: With `auto_mode` low, `lock_lost` has no effect on `mux_sel` and never produces `switch_evt`.
- R11: A selection change caused by `ref_pick` in manual mode does not produce `switch_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pick | input | 1 | Manual reference choice, asynchronous |
| auto_mode | input | 1 | 1 enables automatic failover, asynchronous |
| lock_lost | input | 1 | PLL loss-of-lock flag, asynchronous |
| mux_sel | output | 1 | Select line for the reference clock mux |
| ref_ack | output | 1 | Reports the reference routed to the phase detector |
| switch_evt | output | 1 | One-cycle pulse on each automatic reselection |

## Verification
The bench aims at the fault filter boundary. A burst one cycle shorter than the threshold must leave the selection alone. A design that counts off by one would switch on that burst, or would switch one cycle late on the full run. It holds loss-of-lock high and toggles it after a switch, where a design without the one-shot latch would bounce back and forth between the references. It also moves the select pin during automatic mode and drives loss-of-lock during manual mode, which catches a design that keeps following the pin or fails over when it should not. A random phase is then compared cycle by cycle against a behavioural model to expose any other mismatch in latency or state.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_MANUAL  = 2'd0,
        MODE_ARMED   = 2'd1,
        MODE_LATCHED = 2'd2
    } sel_mode_e;

    typedef struct packed {
        sel_mode_e mode;
        logic      sel;
        logic      evt;
    } sel_state_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/refsel_fault_filter.sv
module refsel_fault_filter #(
    parameter int FAULT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lol_s,
    output logic fault_o
);
    localparam int CNT_W = $clog2(FAULT_CYCLES + 1);
    localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(FAULT_CYCLES);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FAULT_CYCLES - 1);

    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!lol_s)                run_d = '0;
        else if (run_q != SAT_VAL) run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign fault_o = lol_s && (run_q >= LAST_VAL);

    assert_run_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= SAT_VAL);

    assert_fault_needs_lol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> lol_s);

    generate
        if (FAULT_CYCLES > 1) begin : g_multi
            assert_fault_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (lol_s && !$past(lol_s)) |-> !fault_o);
        end
    endgenerate
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pick_s,
    input  logic auto_s,
    input  logic fault_i,
    output logic sel_o,
    output logic evt_o
);
    sel_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.evt = 1'b0;
        unique case (cur_q.mode)
            MODE_MANUAL: begin
                nxt_d.sel = pick_s;
                if (auto_s) nxt_d.mode = MODE_ARMED;
            end
            MODE_ARMED: begin
                if (!auto_s) begin
                    nxt_d.mode = MODE_MANUAL;
                    nxt_d.sel  = pick_s;
                end else if (fault_i) begin
                    nxt_d.mode = MODE_LATCHED;
                    nxt_d.sel  = ~cur_q.sel;
                    nxt_d.evt  = 1'b1;
                end
            end
            MODE_LATCHED: begin
                if (!auto_s) begin
                    nxt_d.mode = MODE_MANUAL;
                    nxt_d.sel  = pick_s;
                end
            end
            default: begin
                nxt_d.mode = MODE_MANUAL;
                nxt_d.sel  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= MODE_MANUAL;
            cur_q.sel  <= 1'b0;
            cur_q.evt  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sel_o = cur_q.sel;
    assign evt_o = cur_q.evt;

    assert_manual_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_s |=> (sel_o == $past(pick_s)));

    assert_evt_flips_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (sel_o != $past(sel_o)));

    assert_evt_from_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(fault_i) && $past(auto_s));

    assert_single_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MODE_LATCHED && auto_s) |=> $stable(sel_o) && !evt_o);

    assert_manual_no_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_s |=> !evt_o);
endmodule

// File: rtl/refclk_autoselect.sv
module refclk_autoselect #(
    parameter int SYNC_STAGES  = 2,
    parameter int FAULT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pick,
    input  logic auto_mode,
    input  logic lock_lost,
    output logic mux_sel,
    output logic ref_ack,
    output logic switch_evt
);
    localparam int NUM_CTRL = 3;

    logic [NUM_CTRL-1:0] ctrl_raw, ctrl_s;
    logic                fault;
    logic                sel;

    assign ctrl_raw = {lock_lost, auto_mode, ref_pick};

    refsel_sync #(
        .WIDTH (NUM_CTRL),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ctrl_raw),
        .sync_o (ctrl_s)
    );

    refsel_fault_filter #(
        .FAULT_CYCLES(FAULT_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .lol_s  (ctrl_s[2]),
        .fault_o(fault)
    );

    refsel_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pick_s (ctrl_s[0]),
        .auto_s (ctrl_s[1]),
        .fault_i(fault),
        .sel_o  (sel),
        .evt_o  (switch_evt)
    );

    assign mux_sel = sel;
    assign ref_ack = sel;

    assert_reset_ref0_R1: assert property (@(posedge clk)
        !rst_n |=> !mux_sel && !switch_evt);
endmodule

// File: tb/sim_refclk_autoselect.sv
module sim_refclk_autoselect;
    localparam int SYNC = 2;
    localparam int NF   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pick = 1'b0, auto_mode = 1'b0, lock_lost = 1'b0;
    logic mux_sel, ref_ack, switch_evt;

    int checks = 0;
    int fails = 0;
    int evt_seen = 0;
    bit done = 1'b0;
    string phase_req = "R1";

    always #10 clk = ~clk;

    refclk_autoselect #(.SYNC_STAGES(SYNC), .FAULT_CYCLES(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_pick(ref_pick), .auto_mode(auto_mode),
        .lock_lost(lock_lost), .mux_sel(mux_sel), .ref_ack(ref_ack),
        .switch_evt(switch_evt)
    );

    // behavioural reference model
    bit q_pick[$], q_auto[$], q_lol[$];
    int m_mode = 0;  // 0 manual, 1 armed, 2 latched
    int m_run = 0;
    bit m_sel = 0, m_evt = 0;

    task automatic model_clear();
        q_pick = {}; q_auto = {}; q_lol = {};
        for (int i = 0; i < SYNC; i++) begin
            q_pick.push_front(1'b0); q_auto.push_front(1'b0); q_lol.push_front(1'b0);
        end
        m_mode = 0; m_run = 0; m_sel = 0; m_evt = 0;
    endtask

    initial model_clear();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit p, a, l, flt;
            p = q_pick.pop_back(); a = q_auto.pop_back(); l = q_lol.pop_back();
            q_pick.push_front(ref_pick); q_auto.push_front(auto_mode); q_lol.push_front(lock_lost);
            flt = l && (m_run >= NF - 1);
            m_run = l ? ((m_run < NF) ? m_run + 1 : m_run) : 0;
            m_evt = 0;
            if (!a) begin
                m_mode = 0; m_sel = p;
            end else if (m_mode == 0) begin
                m_mode = 1; m_sel = p;
            end else if (m_mode == 1 && flt) begin
                m_mode = 2; m_sel = !m_sel; m_evt = 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase_req, mux_sel, m_sel, "mux_sel vs model");
            check("R3", ref_ack, mux_sel, "ref_ack vs mux_sel");
            check(phase_req, switch_evt, m_evt, "switch_evt vs model");
            if (switch_evt) evt_seen++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        check("R1", mux_sel, 0, "mux_sel in reset");
        check("R1", switch_evt, 0, "switch_evt in reset");
        rst_n = 1'b1;
        step(1);
        check("R1", mux_sel, 0, "mux_sel after reset");
        check("R1", ref_ack, 0, "ref_ack after reset");

        // manual following and latency
        phase_req = "R2";
        ref_pick = 1'b1;
        step(SYNC);
        check("R2", mux_sel, 0, "before manual latency");
        step(1);
        check("R2", mux_sel, 1, "after manual latency");
        check("R11", switch_evt, 0, "no event on manual change");

        // loss of lock in manual mode
        phase_req = "R10";
        evt_seen = 0;
        lock_lost = 1'b1;
        step(3 * NF + 8);
        ref_pick = 1'b0;
        step(SYNC + 2);
        lock_lost = 1'b0;
        check("R10", mux_sel, 0, "manual ignores lol");
        check("R10", evt_seen, 0, "no events in manual");
        step(4);

        // entering auto adopts the pin
        phase_req = "R4";
        ref_pick = 1'b1;
        step(SYNC + 2);
        auto_mode = 1'b1;
        step(SYNC + 2);
        check("R4", mux_sel, 1, "auto adopts pin");

        // pin ignored during auto
        phase_req = "R5";
        ref_pick = 1'b0;
        step(SYNC + 4);
        check("R5", mux_sel, 1, "pin ignored in auto");

        // short burst
        phase_req = "R6";
        lock_lost = 1'b1;
        step(NF - 1);
        lock_lost = 1'b0;
        step(SYNC + NF + 4);
        check("R6", mux_sel, 1, "short burst no switch");

        // full run switches
        phase_req = "R7";
        lock_lost = 1'b1;
        step(SYNC + NF - 1);
        check("R7", mux_sel, 1, "one edge before switch");
        check("R7", switch_evt, 0, "no event before switch");
        step(1);
        check("R7", mux_sel, 0, "switched to other ref");
        check("R7", switch_evt, 1, "event pulse");
        step(1);
        check("R7", switch_evt, 0, "event one cycle only");

        // non-revertive
        phase_req = "R8";
        evt_seen = 0;
        step(20);
        for (int i = 0; i < 6; i++) begin
            lock_lost = ~lock_lost;
            step(NF + 2);
        end
        lock_lost = 1'b1;
        step(3 * NF);
        check("R8", mux_sel, 0, "stays after switch");
        check("R8", evt_seen, 0, "no second event");

        // re-arm
        phase_req = "R9";
        lock_lost = 1'b0;
        auto_mode = 1'b0;
        step(SYNC + 3);
        auto_mode = 1'b1;
        step(SYNC + 3);
        check("R9", mux_sel, 0, "rearmed on ref0");
        lock_lost = 1'b1;
        step(SYNC + NF);
        check("R9", mux_sel, 1, "second switch after rearm");
        check("R9", switch_evt, 1, "event after rearm");
        lock_lost = 1'b0;
        step(5);

        // random stress against the model
        phase_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) auto_mode = ~auto_mode;
            else if (r < 8) ref_pick = ~ref_pick;
            else if (r < 20) lock_lost = ~lock_lost;
            step(1);
        end

        finish_run();
    end
endmodule